// File: doc/BRIEF.md
# Processor Core Power-Down Sequencer

This block switches off one processor core out of a small cluster on request. A requester presents a one-hot core selection together with a single-cycle start strobe. The sequencer then watches the per-core wait-for-interrupt status lines until the chosen core reports that it is idle. It re-examines that line on every clock for as long as the core stays busy.

Once the core is idle, the sequencer works through a fixed order of steps, one register update per cycle. First it engages the core's output isolation clamp; this step is skipped for core 0, whose clamp also cuts off shared logic and would stall the system. Next it drives the core's active-low reset line low. Then it writes the all-off code into the core's power-switch control byte. Finally it raises a one-cycle done pulse, which releases the shared management resource, and it drops back to idle.

In every step, the bits and bytes that belong to the other cores are left as they were. All control outputs are registered and keep their values from one sequence to the next.

Top module: `core_pwrdn_seq`

## Requirements
- R1: The core selection is a one-hot mask with bit i standing for core i (4 cores by default). A start is accepted when start_i is 1 at a rising edge while busy_o is 0 and exactly one mask bit is set.
- R2: After an accepted start, no clamp, reset or power-switch output changes until a rising edge at which idle_i bit i of the selected core is 1. The idle bits of other cores have no effect, and the selected bit is re-sampled on every cycle while it is 0.
- R3: For a selected core other than core 0, clamp_o bit i becomes 1 one cycle after the edge where the idle bit was seen. The other clamp bits are unchanged.
- R4: For core 0, clamp_o is never changed, and the reset step follows directly one cycle after the idle bit was seen.
- R5: rstn_o bit i (active low) is cleared one cycle after the clamp step, or one cycle after the idle edge for core 0. The other reset bits are unchanged.
- R6: The power-switch byte of core i, psw_o bits [8*i+7 : 8*i], becomes 8'hFF (all switches off) one cycle after the reset step. The other bytes are unchanged, and a byte only ever changes to 8'hFF.
- R7: done_o is high for exactly one cycle, one cycle after the power-switch step. busy_o falls on that same edge, after which the sequencer is idle and can accept a new start.
- R8: busy_o rises on the edge that accepts a start and stays high until done_o. A start seen while busy_o is 1 is ignored: the selection does not change and no error is flagged.
- R9: A start with zero or more than one mask bit set, seen while idle, pulses err_o for one cycle. busy_o stays 0 and no clamp, reset or power-switch output changes.
- R10: Reset (synchronous, active high) sets clamp_o to all 0, rstn_o to all 1, every power-switch byte to 8'h00, and busy_o, done_o and err_o to 0. Outside reset, these registers keep their values from one sequence to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a power-down request |
| core_mask_i | input | NUM_CORES | One-hot selection of the core to power down |
| idle_i | input | NUM_CORES | Per-core wait-for-interrupt status, 1 = idle |
| busy_o | output | 1 | High while a sequence is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence, which releases the resource |
| err_o | output | 1 | One-cycle pulse when a start carries an invalid mask |
| clamp_o | output | NUM_CORES | Per-core output isolation clamps, 1 = clamped |
| rstn_o | output | NUM_CORES | Per-core active-low reset lines |
| psw_o | output | NUM_CORES*PSW_W | Per-core power-switch control bytes, with core i in byte lane i |

## Verification
Let E be the edge at which the selected idle bit is first seen high. The clamp bit then changes after E+1, the reset bit after E+2 and the power byte after E+3; for core 0 the reset and power steps move one edge earlier. done_o is high after E+4 (E+3 for core 0), and busy_o rises on the edge that accepts the start while err_o follows an invalid start by one edge. The bench keeps a behavioural model that applies these delays to the inputs it sampled at each rising edge. It compares every output with the model at the falling edge, so each result is checked in the exact cycle it is due and no earlier or later. Directed checks add to this: other cores reporting idle while the target stays busy, a start while busy, invalid masks, and the core 0 skip.

// File: rtl/core_pwrdn_pkg.sv
package core_pwrdn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_CLAMP = 3'd2,
    ST_RESET = 3'd3,
    ST_POWER = 3'd4,
    ST_DONE  = 3'd5
  } seq_state_e;

endpackage

// File: rtl/cpd_mask_decode.sv
module cpd_mask_decode #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES-1:0] mask_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);

  // Exactly one bit set is a legal request.
  assign valid_o = ($countones(mask_i) == 1);

  // OR-encode the position of the set bit.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (mask_i[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/cpd_seq_fsm.sv
module cpd_seq_fsm
  import core_pwrdn_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int ISO_SKIP_CORE = 0,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 mask_valid_i,
  input  logic [NUM_CORES-1:0] mask_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_CORES-1:0] idle_i,
  output logic [IDX_W-1:0]     sel_idx_o,
  output logic                 clamp_we_o,
  output logic                 rst_we_o,
  output logic                 psw_we_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o
);

  seq_state_e           state_q;
  logic [NUM_CORES-1:0] sel_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 target_idle;
  logic                 skip_iso;

  assign target_idle = |(idle_i & sel_q);
  assign skip_iso    = sel_q[ISO_SKIP_CORE];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      idx_q   <= '0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (mask_valid_i) begin
              sel_q   <= mask_i;
              idx_q   <= idx_i;
              busy_o  <= 1'b1;
              state_q <= ST_WAIT;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (target_idle) state_q <= skip_iso ? ST_RESET : ST_CLAMP;
        end
        ST_CLAMP: state_q <= ST_RESET;
        ST_RESET: state_q <= ST_POWER;
        ST_POWER: state_q <= ST_DONE;
        ST_DONE: begin
          done_o  <= 1'b1;
          busy_o  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_idx_o  = idx_q;
  assign clamp_we_o = (state_q == ST_CLAMP);
  assign rst_we_o   = (state_q == ST_RESET);
  assign psw_we_o   = (state_q == ST_POWER);

endmodule

// File: rtl/cpd_core_regs.sv
module cpd_core_regs #(
  parameter int NUM_CORES = 4,
  parameter int PSW_W     = 8,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam logic [PSW_W-1:0] PSW_ON  = '0,
  localparam logic [PSW_W-1:0] PSW_OFF = '1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic                       clamp_we_i,
  input  logic                       rst_we_i,
  input  logic                       psw_we_i,
  output logic [NUM_CORES-1:0]       clamp_o,
  output logic [NUM_CORES-1:0]       rstn_o,
  output logic [NUM_CORES*PSW_W-1:0] psw_o
);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic             hit;
    logic             clamp_q;
    logic             rstn_q;
    logic [PSW_W-1:0] psw_q;

    assign hit = (idx_i == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        clamp_q <= 1'b0;
        rstn_q  <= 1'b1;
        psw_q   <= PSW_ON;
      end else begin
        if (clamp_we_i && hit) clamp_q <= 1'b1;
        if (rst_we_i && hit)   rstn_q  <= 1'b0;
        if (psw_we_i && hit)   psw_q   <= PSW_OFF;
      end
    end

    assign clamp_o[i]               = clamp_q;
    assign rstn_o[i]                = rstn_q;
    assign psw_o[i*PSW_W +: PSW_W]  = psw_q;
  end

endmodule

// File: rtl/core_pwrdn_seq.sv
module core_pwrdn_seq #(
  parameter int NUM_CORES     = 4,
  parameter int PSW_W         = 8,
  parameter int ISO_SKIP_CORE = 0,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [NUM_CORES-1:0]       core_mask_i,
  input  logic [NUM_CORES-1:0]       idle_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic [NUM_CORES-1:0]       clamp_o,
  output logic [NUM_CORES-1:0]       rstn_o,
  output logic [NUM_CORES*PSW_W-1:0] psw_o
);

  logic             mask_valid;
  logic [IDX_W-1:0] req_idx;
  logic [IDX_W-1:0] sel_idx;
  logic             clamp_we;
  logic             rst_we;
  logic             psw_we;

  cpd_mask_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .mask_i  (core_mask_i),
    .valid_o (mask_valid),
    .idx_o   (req_idx)
  );

  cpd_seq_fsm #(.NUM_CORES(NUM_CORES), .ISO_SKIP_CORE(ISO_SKIP_CORE)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .mask_valid_i (mask_valid),
    .mask_i       (core_mask_i),
    .idx_i        (req_idx),
    .idle_i       (idle_i),
    .sel_idx_o    (sel_idx),
    .clamp_we_o   (clamp_we),
    .rst_we_o     (rst_we),
    .psw_we_o     (psw_we),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  cpd_core_regs #(.NUM_CORES(NUM_CORES), .PSW_W(PSW_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .idx_i      (sel_idx),
    .clamp_we_i (clamp_we),
    .rst_we_i   (rst_we),
    .psw_we_i   (psw_we),
    .clamp_o    (clamp_o),
    .rstn_o     (rstn_o),
    .psw_o      (psw_o)
  );

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
  parameter int NUM_CORES     = 4,
  parameter int PSW_W         = 8,
  parameter int ISO_SKIP_CORE = 0
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       busy_o,
  input logic                       done_o,
  input logic                       err_o,
  input logic [NUM_CORES-1:0]       clamp_o,
  input logic [NUM_CORES-1:0]       rstn_o,
  input logic [NUM_CORES*PSW_W-1:0] psw_o
);

  // R4: the shared-logic clamp is never engaged
  p_no_clamp_core0_r4: assert property (@(posedge clk) disable iff (rst)
    !$rose(clamp_o[ISO_SKIP_CORE]));

  // R5: at most one reset line goes low per cycle
  p_one_reset_step_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0($past(rstn_o) & ~rstn_o));

  // R3: a core other than core 0 is clamped before its reset falls
  for (genvar j = 0; j < NUM_CORES; j++) begin : g_order
    if (j != ISO_SKIP_CORE) begin : g_iso
      p_clamp_before_reset_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rstn_o[j]) |-> clamp_o[j]);
    end
    // R6: a power byte only ever moves to all-off
    p_psw_only_off_r6: assert property (@(posedge clk) disable iff (rst)
      !$stable(psw_o[j*PSW_W +: PSW_W]) |-> (psw_o[j*PSW_W +: PSW_W] == '1));
  end

  // R7: done is a single-cycle pulse with busy already low
  p_done_clears_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_busy_falls_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R8: no error can follow a start issued while busy
  p_busy_no_err_r8: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !err_o);

  // R8: control registers only move during a sequence
  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> ($stable(clamp_o) && $stable(rstn_o) && $stable(psw_o)));

  // R9: an invalid request leaves the sequencer idle
  p_err_stays_idle_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !busy_o);

endmodule

bind core_pwrdn_seq cpd_checker #(
  .NUM_CORES(NUM_CORES), .PSW_W(PSW_W), .ISO_SKIP_CORE(ISO_SKIP_CORE)
) chk_i (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .clamp_o(clamp_o), .rstn_o(rstn_o), .psw_o(psw_o)
);

// File: tb/core_pwrdn_seq_tb.sv
`timescale 1ns/1ps
module core_pwrdn_seq_tb_top;

  localparam int NC = 4;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [NC-1:0] core_mask_i = '0;
  logic [NC-1:0] idle_i = '0;
  logic          busy_o, done_o, err_o;
  logic [NC-1:0] clamp_o, rstn_o;
  logic [NC*PW-1:0] psw_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  core_pwrdn_seq #(.NUM_CORES(NC), .PSW_W(PW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .core_mask_i(core_mask_i),
    .idle_i(idle_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .clamp_o(clamp_o), .rstn_o(rstn_o), .psw_o(psw_o)
  );

  // Behavioural reference: a step counter, with the due cycles taken from the requirements
  int          m_step;
  logic [NC-1:0] m_sel;
  logic [NC-1:0] m_clamp, m_rstn;
  logic [NC*PW-1:0] m_psw;
  logic        m_busy, m_done, m_err;

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_sel = '0; m_clamp = '0; m_rstn = '1; m_psw = '0;
      m_busy = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_step == 0) begin
        if (start_i) begin
          if ($countones(core_mask_i) == 1) begin
            m_sel = core_mask_i; m_busy = 1; m_step = 1;
          end else m_err = 1;
        end
      end else if (m_step == 1) begin
        if ((idle_i & m_sel) != 0) m_step = (m_sel == 4'b0001) ? 3 : 2;
      end else if (m_step == 2) begin
        m_clamp = m_clamp | m_sel; m_step = 3;
      end else if (m_step == 3) begin
        m_rstn = m_rstn & ~m_sel; m_step = 4;
      end else if (m_step == 4) begin
        for (int k = 0; k < NC; k++) if (m_sel[k]) m_psw[k*PW +: PW] = 8'hFF;
        m_step = 5;
      end else begin
        m_done = 1; m_busy = 0; m_step = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3/R4 clamp_o", 64'(clamp_o), 64'(m_clamp));
      chk("R5 rstn_o", 64'(rstn_o), 64'(m_rstn));
      chk("R6 psw_o", 64'(psw_o), 64'(m_psw));
      chk("R8 busy_o", 64'(busy_o), 64'(m_busy));
      chk("R7 done_o", 64'(done_o), 64'(m_done));
      chk("R9 err_o", 64'(err_o), 64'(m_err));
    end
  end

  task automatic pulse_start(input logic [NC-1:0] m);
    @(negedge clk); start_i = 1'b1; core_mask_i = m;
    @(negedge clk); start_i = 1'b0; core_mask_i = '0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (done_o) return;
    end
    chk("R7 done timeout", 64'd0, 64'd1);
  endtask

  // Start, hold the target busy for 'hold' cycles while other cores report idle
  task automatic run_core(input logic [NC-1:0] m, input int hold);
    idle_i = ~m;
    pulse_start(m);
    for (int t = 0; t < hold; t++) @(negedge clk);
    idle_i = m;
    wait_done();
    idle_i = '0;
  endtask

  logic [NC-1:0]    snap_c, snap_r;
  logic [NC*PW-1:0] snap_p;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset clamp", 64'(clamp_o), 64'h0);
    chk("R10 reset rstn", 64'(rstn_o), 64'hF);
    chk("R10 reset psw", 64'(psw_o), 64'h0);
    chk("R10 reset busy", 64'(busy_o), 64'h0);

    // Core 2, target stays busy while the others report idle; start while busy
    idle_i = 4'b1011;
    pulse_start(4'b0100);
    chk("R8 busy after start", 64'(busy_o), 64'h1);
    pulse_start(4'b0010);  // ignored
    repeat (6) @(negedge clk);
    chk("R2 no clamp while target busy", 64'(clamp_o), 64'h0);
    chk("R2 no reset while target busy", 64'(rstn_o), 64'hF);
    idle_i = 4'b0100;
    wait_done();
    idle_i = '0;
    chk("R1 lane 2 off", 64'(psw_o), 64'h00FF0000);
    chk("R8 ignored start left core1", 64'(clamp_o[1]), 64'h0);

    // Invalid requests
    snap_c = clamp_o; snap_r = rstn_o; snap_p = psw_o;
    @(negedge clk); start_i = 1'b1; core_mask_i = 4'b0000;
    @(negedge clk); start_i = 1'b0;
    chk("R9 err on empty mask", 64'(err_o), 64'h1);
    @(negedge clk); start_i = 1'b1; core_mask_i = 4'b0110;
    @(negedge clk); start_i = 1'b0; core_mask_i = '0;
    chk("R9 err on two bits", 64'(err_o), 64'h1);
    repeat (5) @(negedge clk);
    chk("R9 busy stays low", 64'(busy_o), 64'h0);
    chk("R9 outputs unchanged", {clamp_o, rstn_o, psw_o}, {snap_c, snap_r, snap_p});

    run_core(4'b0001, 3);
    chk("R4 core0 not clamped", 64'(clamp_o[0]), 64'h0);
    chk("R4 core0 reset", 64'(rstn_o[0]), 64'h0);
    run_core(4'b1000, 0);
    run_core(4'b0010, 2);
    run_core(4'b0100, 1);  // repeat: state persists
    chk("R10 clamps kept", 64'(clamp_o), 64'hE);
    chk("R10 resets kept", 64'(rstn_o), 64'h0);
    chk("R6 all lanes off", 64'(psw_o), 64'hFFFFFFFF);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule